// File: doc/BRIEF.md
# Speculative Future File Register Bank

This block keeps the integer register state of an out-of-order core in two copies. A speculative copy holds the newest value produced for each of the 16 architectural registers. Issued micro-ops read their operands from it and write their results into it. A committed copy holds the non-speculative value of each architectural register and changes only when a micro-op retires. A further 8 scratch registers serve microcode and sit beside the architectural ones.

When a mispredicted branch or an exception forces recovery, a single `flush` pulse loads the whole committed copy into the speculative copy in one clock. The scratch registers keep their contents. Three issue lanes each have a pair of operand read ports and one speculative write port. Three retire lanes update the committed copy. Reads are combinational and forward any same-cycle speculative write, so a dependent operand never waits for the register update.

Addresses are 6 bits wide. Indices 0 to 15 name architectural registers and indices 32 to 39 name scratch registers. Every other index is unmapped.

Top module: `ffrb_bank`

## Requirements
- R1: After reset, a read of every index in 0..15 and 32..39 returns zero.
- R2: A speculative write (`sp_en` set, index 0..15) stores its data in the speculative copy, and reads return that data from the next cycle on. The committed copy is left unchanged.
- R3: A retire write (`rt_en` set, index 0..15) updates only the committed copy. Reads of that register keep returning the speculative value until a flush occurs.
- R4: When several lanes of one write group (speculative or retire) target the same register in the same cycle, the lane with the highest number wins.
- R5: Outside a flush cycle, a read whose index matches a same-cycle speculative write returns the write data of the highest matching lane in that same cycle.
- R6: In the cycle after `flush` is high, every speculative entry 0..15 equals the committed copy, including any retire writes made in the flush cycle.
- R7: Speculative writes presented in a flush cycle are discarded, both to architectural and to scratch indices. Reads in that cycle return the stored pre-flush values without forwarding.
- R8: Scratch indices 32..39 are read and written through the speculative ports and forward like architectural registers. A flush leaves them unchanged, and retire writes to them are ignored.
- R9: Reads of indices 16..31 and 40..63 return zero, and writes to those indices change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Recovery request: restore the speculative copy from the committed copy |
| rd_addr | input | 6x6 | Operand read indices; ports 2k and 2k+1 belong to lane k |
| rd_data | output | 6x64 | Operand read data |
| sp_en | input | 3 | Speculative write enable per lane |
| sp_addr | input | 3x6 | Speculative write index per lane |
| sp_data | input | 3x64 | Speculative write data per lane |
| rt_en | input | 3 | Retire write enable per lane |
| rt_addr | input | 3x6 | Retire write index per lane |
| rt_data | input | 3x64 | Retire write data per lane |

## Verification
A corrupted committed entry stays hidden while execution runs without recovery. It shows at the read ports in the cycle right after the next flush, so the random stimulus pairs frequent flushes with heavy retire traffic. A corrupted speculative entry or a wrong forwarding choice shows on the same or the next read of that index. Random indices span the whole 6-bit range, so the stimulus hits lane collisions, unmapped indices and scratch accesses within a few hundred cycles.

// File: rtl/ffrb_pkg.sv
package ffrb_pkg;
    // Default geometry of the bank
    localparam int unsigned FFRB_XLEN     = 64;
    localparam int unsigned FFRB_ARCH_N   = 16;
    localparam int unsigned FFRB_SCR_N    = 8;
    localparam int unsigned FFRB_SCR_BASE = 32;
    localparam int unsigned FFRB_LANES    = 3;
    localparam int unsigned FFRB_AW       = 6;

    // Which storage an index selects
    typedef enum logic [1:0] {
        RGN_ARCH = 2'd0,
        RGN_SCR  = 2'd1,
        RGN_NONE = 2'd2
    } ffrb_region_e;
endpackage

// File: rtl/ffrb_wr_merge.sv
// Per-register merge of a group of write lanes; later lanes override earlier ones.
module ffrb_wr_merge #(
    parameter int unsigned LANES = 3,
    parameter int unsigned AW    = 6,
    parameter int unsigned XLEN  = 64,
    parameter int unsigned BASE  = 0,
    parameter int unsigned COUNT = 16
) (
    input  logic [LANES-1:0]           en,
    input  logic [LANES-1:0][AW-1:0]   addr,
    input  logic [LANES-1:0][XLEN-1:0] data,
    output logic [COUNT-1:0]           hit,
    output logic [COUNT-1:0][XLEN-1:0] val
);
    for (genvar g = 0; g < COUNT; g++) begin : g_reg
        always_comb begin
            hit[g] = 1'b0;
            val[g] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (en[l] && (addr[l] == AW'(BASE + g))) begin
                    hit[g] = 1'b1;
                    val[g] = data[l];
                end
            end
        end
    end
endmodule

// File: rtl/ffrb_rd_port.sv
// One operand read port: region decode, storage select and same-cycle forwarding.
module ffrb_rd_port
    import ffrb_pkg::*;
#(
    parameter int unsigned AW       = 6,
    parameter int unsigned XLEN     = 64,
    parameter int unsigned ARCH_N   = 16,
    parameter int unsigned SCR_N    = 8,
    parameter int unsigned SCR_BASE = 32
) (
    input  logic [AW-1:0]               addr,
    input  logic                        flush,
    input  logic [ARCH_N-1:0][XLEN-1:0] fut,
    input  logic [SCR_N-1:0][XLEN-1:0]  scr,
    input  logic [ARCH_N-1:0]           fwd_hit_a,
    input  logic [ARCH_N-1:0][XLEN-1:0] fwd_val_a,
    input  logic [SCR_N-1:0]            fwd_hit_s,
    input  logic [SCR_N-1:0][XLEN-1:0]  fwd_val_s,
    output logic [XLEN-1:0]             data
);
    ffrb_region_e rgn;
    logic [XLEN-1:0] arch_v, scr_v;

    always_comb begin
        rgn    = RGN_NONE;
        arch_v = '0;
        scr_v  = '0;
        for (int i = 0; i < ARCH_N; i++) begin
            if (addr == AW'(i)) begin
                rgn    = RGN_ARCH;
                arch_v = (!flush && fwd_hit_a[i]) ? fwd_val_a[i] : fut[i];
            end
        end
        for (int i = 0; i < SCR_N; i++) begin
            if (addr == AW'(SCR_BASE + i)) begin
                rgn   = RGN_SCR;
                scr_v = (!flush && fwd_hit_s[i]) ? fwd_val_s[i] : scr[i];
            end
        end
        unique case (rgn)
            RGN_ARCH: data = arch_v;
            RGN_SCR:  data = scr_v;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/ffrb_bank.sv
module ffrb_bank
    import ffrb_pkg::*;
#(
    parameter int unsigned XLEN     = FFRB_XLEN,
    parameter int unsigned ARCH_N   = FFRB_ARCH_N,
    parameter int unsigned SCR_N    = FFRB_SCR_N,
    parameter int unsigned SCR_BASE = FFRB_SCR_BASE,
    parameter int unsigned LANES    = FFRB_LANES,
    parameter int unsigned AW       = FFRB_AW
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic [2*LANES-1:0][AW-1:0]      rd_addr,
    output logic [2*LANES-1:0][XLEN-1:0]    rd_data,
    input  logic [LANES-1:0]                sp_en,
    input  logic [LANES-1:0][AW-1:0]        sp_addr,
    input  logic [LANES-1:0][XLEN-1:0]      sp_data,
    input  logic [LANES-1:0]                rt_en,
    input  logic [LANES-1:0][AW-1:0]        rt_addr,
    input  logic [LANES-1:0][XLEN-1:0]      rt_data
);
    localparam int unsigned RD_N = 2 * LANES;

    typedef struct packed {
        logic [ARCH_N-1:0][XLEN-1:0] fut;
        logic [ARCH_N-1:0][XLEN-1:0] com;
        logic [SCR_N-1:0][XLEN-1:0]  scr;
    } bank_t;

    bank_t st_d, st_q;

    logic [ARCH_N-1:0]           sp_hit_a, rt_hit_a;
    logic [ARCH_N-1:0][XLEN-1:0] sp_val_a, rt_val_a;
    logic [SCR_N-1:0]            sp_hit_s;
    logic [SCR_N-1:0][XLEN-1:0]  sp_val_s;

    // Views of the stored state for the bound checker
    logic [ARCH_N-1:0][XLEN-1:0] fut_q, com_q;
    logic [SCR_N-1:0][XLEN-1:0]  scr_q;
    assign fut_q = st_q.fut;
    assign com_q = st_q.com;
    assign scr_q = st_q.scr;

    ffrb_wr_merge #(.LANES(LANES), .AW(AW), .XLEN(XLEN), .BASE(0), .COUNT(ARCH_N)) sp_arch_i (
        .en(sp_en), .addr(sp_addr), .data(sp_data), .hit(sp_hit_a), .val(sp_val_a)
    );
    ffrb_wr_merge #(.LANES(LANES), .AW(AW), .XLEN(XLEN), .BASE(SCR_BASE), .COUNT(SCR_N)) sp_scr_i (
        .en(sp_en), .addr(sp_addr), .data(sp_data), .hit(sp_hit_s), .val(sp_val_s)
    );
    ffrb_wr_merge #(.LANES(LANES), .AW(AW), .XLEN(XLEN), .BASE(0), .COUNT(ARCH_N)) rt_arch_i (
        .en(rt_en), .addr(rt_addr), .data(rt_data), .hit(rt_hit_a), .val(rt_val_a)
    );

    for (genvar p = 0; p < RD_N; p++) begin : g_rd
        ffrb_rd_port #(
            .AW(AW), .XLEN(XLEN), .ARCH_N(ARCH_N), .SCR_N(SCR_N), .SCR_BASE(SCR_BASE)
        ) rd_i (
            .addr(rd_addr[p]), .flush(flush), .fut(st_q.fut), .scr(st_q.scr),
            .fwd_hit_a(sp_hit_a), .fwd_val_a(sp_val_a),
            .fwd_hit_s(sp_hit_s), .fwd_val_s(sp_val_s),
            .data(rd_data[p])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ARCH_N; i++) begin
            if (rt_hit_a[i]) st_d.com[i] = rt_val_a[i];
        end
        for (int i = 0; i < ARCH_N; i++) begin
            if (flush)            st_d.fut[i] = st_d.com[i];
            else if (sp_hit_a[i]) st_d.fut[i] = sp_val_a[i];
        end
        for (int i = 0; i < SCR_N; i++) begin
            if (!flush && sp_hit_s[i]) st_d.scr[i] = sp_val_s[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ffrb_bank_chk.sv
module ffrb_bank_chk #(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned ARCH_N   = 16,
    parameter int unsigned SCR_N    = 8,
    parameter int unsigned SCR_BASE = 32,
    parameter int unsigned LANES    = 3,
    parameter int unsigned AW       = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         flush,
    input logic [2*LANES-1:0][AW-1:0]   rd_addr,
    input logic [2*LANES-1:0][XLEN-1:0] rd_data,
    input logic [LANES-1:0]             sp_en,
    input logic [LANES-1:0][AW-1:0]     sp_addr,
    input logic [LANES-1:0][XLEN-1:0]   sp_data,
    input logic [LANES-1:0]             rt_en,
    input logic [ARCH_N-1:0][XLEN-1:0]  fut_q,
    input logic [ARCH_N-1:0][XLEN-1:0]  com_q,
    input logic [SCR_N-1:0][XLEN-1:0]   scr_q
);
    logic a0_mapped, a0_fwd_top;
    assign a0_mapped  = (rd_addr[0] < AW'(ARCH_N)) ||
                        ((rd_addr[0] >= AW'(SCR_BASE)) && (rd_addr[0] < AW'(SCR_BASE + SCR_N)));
    assign a0_fwd_top = !flush && sp_en[LANES-1] && (sp_addr[LANES-1] == rd_addr[0]) && a0_mapped;

    // R3: without retire writes the committed copy holds
    a_r3_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_en == '0) |=> $stable(com_q));

    // R6: one cycle after flush the speculative copy mirrors the committed copy
    a_r6_flush_restore: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fut_q == com_q));

    // R8: scratch registers survive a flush
    a_r8_scratch_keep: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(scr_q));

    // R5: the highest lane forwards to a matching read
    a_r5_fwd_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        a0_fwd_top |-> (rd_data[0] == sp_data[LANES-1]));

    // R9: unmapped indices read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !a0_mapped |-> (rd_data[0] == '0));
endmodule

bind ffrb_bank ffrb_bank_chk #(
    .XLEN(XLEN), .ARCH_N(ARCH_N), .SCR_N(SCR_N), .SCR_BASE(SCR_BASE), .LANES(LANES), .AW(AW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_addr(rd_addr), .rd_data(rd_data),
    .sp_en(sp_en), .sp_addr(sp_addr), .sp_data(sp_data), .rt_en(rt_en),
    .fut_q(fut_q), .com_q(com_q), .scr_q(scr_q)
);

// File: tb/ffrb_bank_tb_top.sv
module ffrb_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush;
    logic [5:0][5:0]  rd_addr;
    logic [5:0][63:0] rd_data;
    logic [2:0]       sp_en, rt_en;
    logic [2:0][5:0]  sp_addr, rt_addr;
    logic [2:0][63:0] sp_data, rt_data;

    logic [63:0] m_fut [16];
    logic [63:0] m_com [16];
    logic [63:0] m_scr [8];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ffrb_bank dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rd_addr(rd_addr), .rd_data(rd_data),
        .sp_en(sp_en), .sp_addr(sp_addr), .sp_data(sp_data),
        .rt_en(rt_en), .rt_addr(rt_addr), .rt_data(rt_data)
    );

    function automatic logic [63:0] exp_rd(logic [5:0] a);
        logic [63:0] v;
        v = '0;
        if (a < 6'd16) begin
            v = m_fut[a[3:0]];
            if (!flush) for (int l = 0; l < 3; l++) if (sp_en[l] && sp_addr[l] == a) v = sp_data[l];
        end else if (a >= 6'd32 && a < 6'd40) begin
            v = m_scr[a[2:0]];
            if (!flush) for (int l = 0; l < 3; l++) if (sp_en[l] && sp_addr[l] == a) v = sp_data[l];
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reads(input string req);
        #1;
        for (int p = 0; p < 6; p++) check(req, rd_data[p], exp_rd(rd_addr[p]));
    endtask

    task automatic idle();
        flush = 1'b0; sp_en = '0; rt_en = '0;
        sp_addr = '0; rt_addr = '0; sp_data = '0; rt_data = '0;
        rd_addr = '0;
    endtask

    // Advance one clock and update the reference model
    task automatic step();
        @(posedge clk);
        for (int l = 0; l < 3; l++) if (rt_en[l] && rt_addr[l] < 6'd16) m_com[rt_addr[l][3:0]] = rt_data[l];
        if (flush) begin
            for (int i = 0; i < 16; i++) m_fut[i] = m_com[i];
        end else begin
            for (int l = 0; l < 3; l++) if (sp_en[l]) begin
                if (sp_addr[l] < 6'd16) m_fut[sp_addr[l][3:0]] = sp_data[l];
                else if (sp_addr[l] >= 6'd32 && sp_addr[l] < 6'd40) m_scr[sp_addr[l][2:0]] = sp_data[l];
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        idle();
        for (int i = 0; i < 16; i++) begin m_fut[i] = '0; m_com[i] = '0; end
        for (int i = 0; i < 8; i++) m_scr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every mapped index reads zero after reset
        for (int a = 0; a < 40; a++) begin
            rd_addr[0] = 6'(a);
            #1 check("R1", rd_data[0], 64'd0);
        end

        // R2: speculative write, visible next cycle
        idle(); sp_en[0] = 1'b1; sp_addr[0] = 6'd5; sp_data[0] = 64'hA5A5;
        step(); idle(); rd_addr[0] = 6'd5;
        #1 check("R2", rd_data[0], 64'hA5A5);

        // R3: retire updates committed copy only
        rt_en[1] = 1'b1; rt_addr[1] = 6'd3; rt_data[1] = 64'hBEEF;
        step(); idle(); rd_addr[0] = 6'd3;
        #1 check("R3", rd_data[0], 64'd0);

        // R4/R5: three lanes collide on r7
        for (int l = 0; l < 3; l++) begin sp_en[l] = 1'b1; sp_addr[l] = 6'd7; sp_data[l] = 64'(100 + l); end
        rd_addr[1] = 6'd7;
        #1 check("R5", rd_data[1], 64'd102);
        rt_en = 3'b011; rt_addr[0] = 6'd8; rt_addr[1] = 6'd8; rt_data[0] = 64'd1; rt_data[1] = 64'd2;
        step(); idle(); rd_addr[1] = 6'd7;
        #1 check("R4", rd_data[1], 64'd102);

        // R6/R7: flush with a discarded speculative write and a same-cycle retire
        flush = 1'b1; sp_en[0] = 1'b1; sp_addr[0] = 6'd9; sp_data[0] = 64'hDEAD;
        sp_en[1] = 1'b1; sp_addr[1] = 6'd33; sp_data[1] = 64'hCAFE;
        rt_en[2] = 1'b1; rt_addr[2] = 6'd10; rt_data[2] = 64'h1234;
        rd_addr[0] = 6'd9; rd_addr[1] = 6'd7;
        #1 check("R7", rd_data[0], 64'd0);
        check("R7", rd_data[1], 64'd102);
        step(); idle();
        rd_addr[0] = 6'd3; rd_addr[1] = 6'd7; rd_addr[2] = 6'd10; rd_addr[3] = 6'd8; rd_addr[4] = 6'd9; rd_addr[5] = 6'd33;
        #1 check("R6", rd_data[0], 64'hBEEF);
        check("R6", rd_data[1], 64'd0);
        check("R6", rd_data[2], 64'h1234);
        check("R4", rd_data[3], 64'd2);
        check("R7", rd_data[4], 64'd0);
        check("R7", rd_data[5], 64'd0);

        // R8: scratch write, then flush and retire to scratch leave it intact
        idle(); sp_en[2] = 1'b1; sp_addr[2] = 6'd38; sp_data[2] = 64'h5C5C;
        rd_addr[0] = 6'd38;
        #1 check("R8", rd_data[0], 64'h5C5C);
        step(); idle(); flush = 1'b1; rt_en[0] = 1'b1; rt_addr[0] = 6'd38; rt_data[0] = 64'h9;
        step(); idle(); rd_addr[0] = 6'd38;
        #1 check("R8", rd_data[0], 64'h5C5C);

        // R9: unmapped writes ignored, unmapped reads zero
        sp_en[0] = 1'b1; sp_addr[0] = 6'd20; sp_data[0] = 64'h77;
        sp_en[1] = 1'b1; sp_addr[1] = 6'd45; sp_data[1] = 64'h88;
        rd_addr[0] = 6'd20; rd_addr[1] = 6'd45; rd_addr[2] = 6'd4;
        #1 check("R9", rd_data[0], 64'd0);
        check("R9", rd_data[1], 64'd0);
        check("R9", rd_data[2], 64'd0);
        step(); idle(); rd_addr[0] = 6'd20; rd_addr[1] = 6'd4; rd_addr[2] = 6'd36;
        check_reads("R9");

        // Random traffic covering R2..R9
        for (int n = 0; n < 3000; n++) begin
            flush = ($urandom_range(0, 15) == 0);
            for (int l = 0; l < 3; l++) begin
                sp_en[l] = $urandom_range(0, 1) == 1;
                sp_addr[l] = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 47)) : 6'($urandom_range(0, 7));
                sp_data[l] = {$urandom, $urandom};
                rt_en[l] = $urandom_range(0, 1) == 1;
                rt_addr[l] = 6'($urandom_range(0, 40));
                rt_data[l] = {$urandom, $urandom};
            end
            for (int p = 0; p < 6; p++)
                rd_addr[p] = ($urandom_range(0, 1) == 1) ? sp_addr[$urandom_range(0, 2)] : 6'($urandom_range(0, 63));
            check_reads(flush ? "R6_R7_random" : "R2_R4_R5_R8_random");
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule